// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sequences a synchronous SRAM into and out of a low-power snooze state. A sleep request arrives as a level that is asynchronous to the clock. It is resynchronised, and the block then steps through a fixed entry window, a snooze state and a fixed exit window. While the sequence is active it tells the SRAM control path to ignore new cycles and tells the data output drivers to go to high impedance. A status flag shows when the array itself is in low power.

Only deselect or read cycles are legal in the cycles just before entry and just after recovery. A write request seen in those windows is a usage error. The block records it in a sticky flag that only reset clears. A sleep request that is too short to cover the entry window still runs a complete entry, and then a complete exit.

Top module: `snooze_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with `sleep_req` low, `in_block`, `out_hiz`, `lowpwr` and `viol` are all 0.
- R2: Call the first rising edge that samples `sleep_req` high edge k. `in_block` is 0 after edge k and 1 after edge k+1. `out_hiz` is 0 after edge k+1 and 1 after edge k+2.
- R3: `lowpwr` stays 0 after edges k+2 and k+3 and becomes 1 after edge k+4. The entry window lasts two cycles.
- R4: Whenever `lowpwr` is 1, `in_block` and `out_hiz` are both 1.
- R5: Call the first edge that samples `sleep_req` low during snooze edge m. `lowpwr` becomes 0 after edge m+2. `in_block` and `out_hiz` stay 1 after edges m+2 and m+3 and fall to 0 after edge m+4, provided `sleep_req` stays low.
- R6: A `sleep_req` pulse that is high for one edge only still gives `lowpwr` = 1 for exactly one cycle, after edge k+4. `in_block` is 1 after edges k+1 to k+6 and `out_hiz` is 1 after edges k+2 to k+6. Both are 0 after edge k+7.
- R7: `viol` is set on an edge where `wr_req` is high while `in_block` is 1 and `lowpwr` is 0. It then stays 1 until reset. `wr_req` has no effect on `viol` while `in_block` is 0 or while `lowpwr` is 1.
- R8: If `sleep_req` rises again during the exit window, the exit still completes. `out_hiz` drops to 0 for exactly one cycle, then a new full entry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request level, asynchronous to `clk` |
| wr_req | input | 1 | A write cycle is being presented to the SRAM control this cycle |
| in_block | output | 1 | Control inputs of the SRAM must be ignored |
| out_hiz | output | 1 | Data outputs must be high impedance |
| lowpwr | output | 1 | Array is in low-power snooze |
| viol | output | 1 | Sticky flag: a write was seen in an entry or exit window |

## Verification
Directed sequences pin down each edge of a long sleep request. They also cover a one-cycle pulse, which shows whether a short request is cut short or runs a full entry. A separate sequence raises the request again inside the exit window, which shows whether the exit is aborted or completed. Writes placed while awake, while snoozed and inside the entry window tell the violation window apart from the states around it. A long random run with mixed hold lengths and random writes then compares every output in every cycle against a bench model built from the requirements.

// File: rtl/snooze_seq.sv
module snooze_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wr_req,
  output logic in_block,
  output logic out_hiz,
  output logic lowpwr,
  output logic viol
);

  localparam int MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  typedef enum logic [1:0] {AWAKE, ENTER, SNOOZE, LEAVE} st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sleep_s;
  st_t                    st;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};

  assign sleep_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= AWAKE;
      cnt <= '0;
    end else begin
      case (st)
        AWAKE:  if (sleep_s) begin st <= ENTER; cnt <= '0; end
        ENTER:  if (cnt == ENTER_LAST) st <= SNOOZE; else cnt <= cnt + 1'b1;
        SNOOZE: if (!sleep_s) begin st <= LEAVE; cnt <= '0; end
        LEAVE:  if (cnt == EXIT_LAST) st <= AWAKE; else cnt <= cnt + 1'b1;
        default: st <= AWAKE;
      endcase
    end
  end

  assign in_block = (st != AWAKE) || sleep_s;
  assign out_hiz  = (st != AWAKE);
  assign lowpwr   = (st == SNOOZE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             viol <= 1'b0;
    else if (wr_req && in_block && !lowpwr) viol <= 1'b1;

  p_snooze_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr |-> (in_block && out_hiz));

  p_hiz_before_lowpwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowpwr) |-> $past(out_hiz));

  p_exit_holds_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lowpwr) |-> (in_block && out_hiz));

  p_hiz_implies_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> in_block);

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

  p_viol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(wr_req && in_block && !lowpwr));

endmodule

// File: tb/snooze_seq_test.sv
`timescale 1ns/1ps
module snooze_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic wr_req = 1'b0;
  logic in_block, out_hiz, lowpwr, viol;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  snooze_seq uut (.clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wr_req(wr_req),
                  .in_block(in_block), .out_hiz(out_hiz), .lowpwr(lowpwr), .viol(viol));

  // Reference model written from the requirements: 0 awake, 1 entry, 2 snooze, 3 exit
  logic m_s1, m_s2, m_viol;
  int m_st, m_n;
  function automatic logic f_blk(int s, logic s2); return (s != 0) || s2; endfunction
  function automatic logic f_hiz(int s); return s != 0; endfunction
  function automatic logic f_low(int s); return s == 2; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_st = 0; m_n = 0; m_viol = 0;
    end else begin
      if (wr_req && f_blk(m_st, m_s2) && !f_low(m_st)) m_viol = 1;
      case (m_st)
        0: if (m_s2) begin m_st = 1; m_n = 1; end
        1: if (m_n == 2) m_st = 2; else m_n++;
        2: if (!m_s2) begin m_st = 3; m_n = 1; end
        default: if (m_n == 2) m_st = 0; else m_n++;
      endcase
      m_s2 = m_s1; m_s1 = sleep_req;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if ({in_block, out_hiz, lowpwr, viol} !==
        {f_blk(m_st, m_s2), f_hiz(m_st), f_low(m_st), m_viol}) begin
      fails++;
      $display("FAIL R2-R8 model: got %b expected %b at %0t", {in_block, out_hiz, lowpwr, viol},
               {f_blk(m_st, m_s2), f_hiz(m_st), f_low(m_st), m_viol}, $time);
    end
  end

  task automatic cyc(input logic s, input logic w);
    sleep_req = s; wr_req = w;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_req = 0; wr_req = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset in_block", in_block, 0);
    chk("R1 reset viol", viol, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_hiz", out_hiz, 0);
    chk("R1 lowpwr", lowpwr, 0);
    chk("R1 viol", viol, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    repeat (3) cyc(0, 1);
    chk("R7 awake write ignored", viol, 0);
    // long request: edge k
    cyc(1, 0); chk("R2 k in_block", in_block, 0);
    cyc(1, 0); chk("R2 k+1 in_block", in_block, 1); chk("R2 k+1 out_hiz", out_hiz, 0);
    cyc(1, 0); chk("R2 k+2 out_hiz", out_hiz, 1); chk("R3 k+2 lowpwr", lowpwr, 0);
    cyc(1, 0); chk("R3 k+3 lowpwr", lowpwr, 0);
    cyc(1, 0); chk("R3 k+4 lowpwr", lowpwr, 1);
    chk("R4 in_block", in_block, 1); chk("R4 out_hiz", out_hiz, 1);
    repeat (3) cyc(1, 1);
    chk("R7 snooze write ignored", viol, 0); chk("R4 still low", lowpwr, 1);
    // exit: edge m
    cyc(0, 0); chk("R5 m lowpwr", lowpwr, 1);
    cyc(0, 0); chk("R5 m+1 lowpwr", lowpwr, 1);
    cyc(0, 0); chk("R5 m+2 lowpwr", lowpwr, 0); chk("R5 m+2 in_block", in_block, 1);
    cyc(0, 0); chk("R5 m+3 out_hiz", out_hiz, 1);
    cyc(0, 0); chk("R5 m+4 in_block", in_block, 0); chk("R5 m+4 out_hiz", out_hiz, 0);
    repeat (3) cyc(0, 0);
    // one-cycle pulse
    for (int j = 0; j <= 8; j++) begin
      cyc(j == 0, 0);
      chk("R6 pulse lowpwr", lowpwr, j == 4);
      chk("R6 pulse in_block", in_block, j >= 1 && j <= 6);
      chk("R6 pulse out_hiz", out_hiz, j >= 2 && j <= 6);
    end
    // re-assert during exit
    repeat (6) cyc(1, 0);
    chk("R8 in snooze", lowpwr, 1);
    cyc(0, 0); cyc(0, 0);
    cyc(1, 0); chk("R8 m+2 exiting", lowpwr, 0);
    cyc(1, 0); chk("R8 m+3 out_hiz", out_hiz, 1);
    cyc(1, 0); chk("R8 m+4 out_hiz gap", out_hiz, 0); chk("R8 m+4 in_block", in_block, 1);
    cyc(1, 0); chk("R8 m+5 out_hiz", out_hiz, 1);
    cyc(1, 0); chk("R8 m+6 lowpwr", lowpwr, 0);
    cyc(1, 0); chk("R8 m+7 lowpwr", lowpwr, 1);
    repeat (2) cyc(0, 0);
    repeat (6) cyc(0, 0);
    // violation in entry window
    do_reset();
    cyc(1, 0); cyc(1, 0);
    chk("R7 before write", viol, 0);
    cyc(1, 1); chk("R7 entry write sets", viol, 1);
    repeat (10) cyc(0, 0);
    chk("R7 sticky", viol, 1);
    do_reset();
    // random mix
    void'($urandom(32'h5a17));
    for (int i = 0; i < 600; i++) begin
      logic s;
      int len;
      s = $urandom_range(1, 0);
      len = $urandom_range(8, 1);
      for (int j = 0; j < len; j++) cyc(s, $urandom_range(3, 0) == 0);
      if ((i % 150) == 149) do_reset();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule